// File: doc/BRIEF.md
# Memristor State Update Engine

This block models the internal state of an emulated memristor in fixed point. Each time a run pulse arrives it takes one 10-bit sample of the voltage across the device and converts it to a signed value. From that value, the present conductance and a window factor read from a table indexed by the state, it forms a drift term and integrates that term into a signed accumulator.

The state is an unsigned code. It moves by one step only when the accumulator has gathered more than one step's worth of drift. When the state moves, the conductance used by later runs is recomputed from the new code. A one-cycle flag then tells the downstream transmitter that a new code is ready. The accumulator keeps any charge left over after a step. Because the resistor array is linear in the code, the code itself is the conductance word sent out.

Each run is a fixed sequence of seven clock cycles. At any usual fabric clock this finishes in well under a microsecond.

Top module: `mstate_engine`

## Requirements
- R1: After reset the state code equals X_INIT, the update flag is low, the accumulator is zero and the stored conductance matches X_INIT.
- R2: A run pulse starts a computation only while the engine is idle. It is ignored during the seven cycles of a computation, and the engine accepts a new pulse in the seventh cycle after the one that started it.
- R3: The sample s is converted to the signed value v = 2*s - 2^SW, so code 2^(SW-1) means zero volts.
- R4: The window factor for state x is floor(4*x*(N-x)*2^FWF / N^2) + EPS, with N = 2^XW - 1, taken from a table indexed by x.
- R5: The drift is computed in three stages, each an arithmetic right shift followed by saturation to DW signed bits: t1 = (v*g)>>>GSH, then t2 = (t1*fw)>>>FWF, then d = (t2*KTS)>>>KSH.
- R6: The accumulator adds d with saturation to QW signed bits.
- R7: If the accumulator is greater than THR, the state rises by one and THR is subtracted. If it is less than -THR, the state falls by one and THR is added. Otherwise nothing changes. At most one step is taken per run, and a value exactly equal to ±THR does not step.
- R8: The state saturates at 0 and at 2^XW - 1. A step that would leave this range leaves the code unchanged and raises no flag, but the accumulator is still reduced by THR.
- R9: When the code changes, the new code and a one-cycle update flag both appear six cycles after the cycle in which the run pulse was accepted. The code never changes without the flag.
- R10: After a change of code, the conductance becomes g = GMIN + floor(x*(GMAX-GMIN)/2^XW), and later runs use this new value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start pulse for one computation |
| sample_i | input | SW | Unsigned voltage sample, read in the accept cycle |
| x_o | output | XW | State code, also the conductance word |
| upd_o | output | 1 | One-cycle pulse when x_o has changed |

## Verification
The bench builds the engine with a 14-bit datapath, a drift gain of four and a threshold of 100, while keeping the 10-bit state and sample. With these values a full-scale sample saturates the last drift stage. Long one-sided runs drive the accumulator into its own saturation and push the code onto both rails within a few thousand cycles. Mixed pseudo-random samples, and extra run pulses issued mid-computation, cover the middle of the range and the busy window.

// File: rtl/mse_pkg.sv
package mse_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MUL_G,
    ST_MUL_W,
    ST_MUL_K,
    ST_ACC,
    ST_CMP,
    ST_GREF
  } mse_state_e;

  // clamp a wide signed value into the range of a w-bit signed word
  function automatic logic signed [63:0] clip_signed(input logic signed [63:0] a,
                                                     input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = (64'sd1 <<< (w - 1)) - 64'sd1;
    lo = -hi - 64'sd1;
    if (a > hi) return hi;
    if (a < lo) return lo;
    return a;
  endfunction

endpackage

// File: rtl/mse_window_rom.sv
module mse_window_rom #(
  parameter int XW  = 10,
  parameter int FWF = 8,
  parameter int EPS = 1
) (
  input  logic [XW-1:0] x_i,
  output logic [FWF:0]  fw_o
);
  localparam int  DEPTH = 1 << XW;
  localparam int  XN    = DEPTH - 1;
  localparam int  FWW   = FWF + 1;

  // window value 1-(2x/N-1)^2 rewritten as 4x(N-x)/N^2, in FWF fractional bits
  function automatic logic [FWW-1:0] fw_entry(input int idx);
    longint num;
    longint den;
    num = longint'(4) * longint'(idx) * longint'(XN - idx) * (longint'(1) << FWF);
    den = longint'(XN) * longint'(XN);
    return FWW'(num / den + longint'(EPS));
  endfunction

  logic [FWW-1:0] rom [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_rom
    assign rom[i] = fw_entry(i);
  end

  assign fw_o = rom[x_i];
endmodule

// File: rtl/mse_drift.sv
module mse_drift import mse_pkg::*; #(
  parameter int SW  = 10,
  parameter int GW  = 12,
  parameter int FWF = 8,
  parameter int DW  = 16,
  parameter int GSH = 10,
  parameter int KTS = 64,
  parameter int KSH = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_g,
  input  logic                 ld_w,
  input  logic                 ld_k,
  input  logic [SW-1:0]        samp_i,
  input  logic [GW-1:0]        g_i,
  input  logic [FWF:0]         fw_i,
  output logic signed [DW-1:0] drift_o
);
  localparam int VW = SW + 1;

  // 2*s - 2^SW: doubling plus flipping the top bit gives the offset form
  function automatic logic signed [VW-1:0] to_volt(input logic [SW-1:0] s);
    return $signed({~s[SW-1], s[SW-2:0], 1'b0});
  endfunction

  logic signed [VW-1:0] volt;
  logic signed [DW-1:0] t1_r, t2_r, t3_r;
  logic signed [63:0]   p_g, p_w, p_k;

  assign volt = to_volt(samp_i);
  assign p_g  = 64'(volt) * 64'($signed({1'b0, g_i}));
  assign p_w  = 64'(t1_r) * 64'($signed({1'b0, fw_i}));
  assign p_k  = 64'(t2_r) * 64'(KTS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_r <= '0;
      t2_r <= '0;
      t3_r <= '0;
    end else begin
      if (ld_g) t1_r <= DW'(clip_signed(p_g >>> GSH, DW));
      if (ld_w) t2_r <= DW'(clip_signed(p_w >>> FWF, DW));
      if (ld_k) t3_r <= DW'(clip_signed(p_k >>> KSH, DW));
    end
  end

  assign drift_o = t3_r;
endmodule

// File: rtl/mse_stepper.sv
module mse_stepper import mse_pkg::*; #(
  parameter int XW     = 10,
  parameter int GW     = 12,
  parameter int GMIN   = 16,
  parameter int GMAX   = 4095,
  parameter int DW     = 16,
  parameter int QW     = 20,
  parameter int THR    = 2048,
  parameter int X_INIT = 512
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 cmp_en,
  input  logic                 gref_en,
  input  logic signed [DW-1:0] drift_i,
  output logic [XW-1:0]        x_o,
  output logic [GW-1:0]        g_o,
  output logic                 upd_o
);
  localparam logic [XW-1:0]        XMAX  = '1;
  localparam logic signed [QW-1:0] THR_Q = QW'(THR);

  function automatic logic [GW-1:0] cond_of(input logic [XW-1:0] x);
    longint span;
    span = longint'(GMAX - GMIN);
    return GW'(longint'(GMIN) + ((longint'(x) * span) >>> XW));
  endfunction

  logic signed [QW-1:0] q_r;
  logic [XW-1:0]        x_r;
  logic [GW-1:0]        g_r;
  logic                 upd_r;
  logic                 over_hi, over_lo, step_up, step_dn;

  assign over_hi = q_r > THR_Q;
  assign over_lo = q_r < -THR_Q;
  assign step_up = cmp_en && over_hi && (x_r != XMAX);
  assign step_dn = cmp_en && over_lo && (x_r != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_r   <= '0;
      x_r   <= XW'(X_INIT);
      g_r   <= cond_of(XW'(X_INIT));
      upd_r <= 1'b0;
    end else begin
      upd_r <= step_up || step_dn;
      if (acc_en) begin
        q_r <= QW'(clip_signed(64'(q_r) + 64'(drift_i), QW));
      end else if (cmp_en && over_hi) begin
        q_r <= q_r - THR_Q;
      end else if (cmp_en && over_lo) begin
        q_r <= q_r + THR_Q;
      end
      if (step_up) x_r <= x_r + 1'b1;
      if (step_dn) x_r <= x_r - 1'b1;
      if (gref_en) g_r <= cond_of(x_r);
    end
  end

  assign x_o   = x_r;
  assign g_o   = g_r;
  assign upd_o = upd_r;
endmodule

// File: rtl/mse_ctrl.sv
module mse_ctrl import mse_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic accept_o,
  output logic ld_g_o,
  output logic ld_w_o,
  output logic ld_k_o,
  output logic acc_o,
  output logic cmp_o,
  output logic gref_o
);
  mse_state_e st_r, st_n;

  always_comb begin
    st_n = st_r;
    unique case (st_r)
      ST_IDLE:  if (run_i) st_n = ST_MUL_G;
      ST_MUL_G: st_n = ST_MUL_W;
      ST_MUL_W: st_n = ST_MUL_K;
      ST_MUL_K: st_n = ST_ACC;
      ST_ACC:   st_n = ST_CMP;
      ST_CMP:   st_n = ST_GREF;
      ST_GREF:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_r <= ST_IDLE;
    else        st_r <= st_n;
  end

  assign accept_o = (st_r == ST_IDLE) && run_i;
  assign ld_g_o   = st_r == ST_MUL_G;
  assign ld_w_o   = st_r == ST_MUL_W;
  assign ld_k_o   = st_r == ST_MUL_K;
  assign acc_o    = st_r == ST_ACC;
  assign cmp_o    = st_r == ST_CMP;
  assign gref_o   = st_r == ST_GREF;
endmodule

// File: rtl/mstate_engine.sv
module mstate_engine #(
  parameter int SW     = 10,
  parameter int XW     = 10,
  parameter int GW     = 12,
  parameter int GMIN   = 16,
  parameter int GMAX   = 4095,
  parameter int FWF    = 8,
  parameter int EPS    = 1,
  parameter int DW     = 16,
  parameter int GSH    = 10,
  parameter int KTS    = 64,
  parameter int KSH    = 6,
  parameter int QW     = 20,
  parameter int THR    = 2048,
  parameter int X_INIT = 512
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic [SW-1:0] sample_i,
  output logic [XW-1:0] x_o,
  output logic          upd_o
);
  logic                 accept, ld_g, ld_w, ld_k, acc_en, cmp_en, gref_en;
  logic [SW-1:0]        samp_r;
  logic [GW-1:0]        g_cur;
  logic [FWF:0]         fw_cur;
  logic signed [DW-1:0] drift;

  always_ff @(posedge clk) begin
    if (!rst_n)      samp_r <= '0;
    else if (accept) samp_r <= sample_i;
  end

  mse_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .accept_o(accept),
    .ld_g_o(ld_g), .ld_w_o(ld_w), .ld_k_o(ld_k),
    .acc_o(acc_en), .cmp_o(cmp_en), .gref_o(gref_en)
  );

  mse_window_rom #(.XW(XW), .FWF(FWF), .EPS(EPS)) u_win (
    .x_i(x_o), .fw_o(fw_cur)
  );

  mse_drift #(.SW(SW), .GW(GW), .FWF(FWF), .DW(DW), .GSH(GSH),
              .KTS(KTS), .KSH(KSH)) u_drift (
    .clk(clk), .rst_n(rst_n), .ld_g(ld_g), .ld_w(ld_w), .ld_k(ld_k),
    .samp_i(samp_r), .g_i(g_cur), .fw_i(fw_cur), .drift_o(drift)
  );

  mse_stepper #(.XW(XW), .GW(GW), .GMIN(GMIN), .GMAX(GMAX), .DW(DW),
                .QW(QW), .THR(THR), .X_INIT(X_INIT)) u_step (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .cmp_en(cmp_en),
    .gref_en(gref_en), .drift_i(drift), .x_o(x_o), .g_o(g_cur), .upd_o(upd_o)
  );
endmodule

// File: rtl/mstate_engine_chk.sv
module mstate_engine_chk #(
  parameter int XW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic          cmp_phase,
  input logic          upd,
  input logic [XW-1:0] x
);
  localparam logic [XW-1:0] XMAX = '1;

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> !upd);

  assert_flag_with_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (x != $past(x)) |-> upd);

  assert_unit_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (x != $past(x)) |-> (({1'b0, x} == {1'b0, $past(x)} + 1'b1) ||
                         ({1'b0, x} + 1'b1 == {1'b0, $past(x)})));

  assert_no_top_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(x) == XMAX) |-> (x != '0));

  assert_no_floor_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(x) == '0) |-> (x != XMAX));

  assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);

  assert_cmp_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_phase |-> $past(accept, 5));
endmodule

bind mstate_engine mstate_engine_chk #(.XW(XW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .cmp_phase(cmp_en),
  .upd(upd_o), .x(x_o)
);

// File: tb/mstate_engine_tb.sv
module mstate_engine_tb;
  localparam int SW = 10, XW = 10, GW = 12, GMIN = 16, GMAX = 4095;
  localparam int FWF = 8, EPS = 1, DW = 14, GSH = 10, KTS = 64, KSH = 4;
  localparam int QW = 20, THR = 100, X_INIT = 512;
  localparam longint XN = (longint'(1) << XW) - 1;

  typedef struct {
    int    cyc;
    int    x;
    bit    upd;
    string req;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run = 1'b0;
  logic [SW-1:0] sample = '0;
  logic [XW-1:0] x_o;
  logic          upd_o;

  int    cnt = 0;
  int    checks = 0;
  int    errors = 0;
  item_t sb[$];

  longint m_x, m_q, m_g;

  always #4 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 1;

  mstate_engine #(
    .SW(SW), .XW(XW), .GW(GW), .GMIN(GMIN), .GMAX(GMAX), .FWF(FWF), .EPS(EPS),
    .DW(DW), .GSH(GSH), .KTS(KTS), .KSH(KSH), .QW(QW), .THR(THR), .X_INIT(X_INIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .sample_i(sample),
    .x_o(x_o), .upd_o(upd_o)
  );

  function automatic longint lim(input longint a, input int w);
    longint top;
    top = (longint'(1) << (w - 1)) - 1;
    if (a > top) return top;
    if (a < -top - 1) return -top - 1;
    return a;
  endfunction

  // R4: window as 1-(2x/N-1)^2 on the integer code, plus epsilon
  function automatic longint win_of(input longint x);
    longint d;
    d = 2 * x - XN;
    return ((XN * XN - d * d) * (longint'(1) << FWF)) / (XN * XN) + EPS;
  endfunction

  // R10: conductance from code
  function automatic longint cond_of(input longint x);
    return GMIN + ((x * (GMAX - GMIN)) >>> XW);
  endfunction

  // reference for R3, R5, R6, R7, R8
  task automatic model_run(input int s, output bit chg);
    longint v, t1, t2, t3;
    v  = 2 * longint'(s) - (longint'(1) << SW);
    t1 = lim((v * m_g) >>> GSH, DW);
    t2 = lim((t1 * win_of(m_x)) >>> FWF, DW);
    t3 = lim((t2 * KTS) >>> KSH, DW);
    m_q = lim(m_q + t3, QW);
    chg = 1'b0;
    if (m_q > THR) begin
      m_q -= THR;
      if (m_x < XN) begin m_x++; chg = 1'b1; end
    end else if (m_q < -THR) begin
      m_q += THR;
      if (m_x > 0) begin m_x--; chg = 1'b1; end
    end
    if (chg) m_g = cond_of(m_x);
  endtask

  task automatic push(input int c, input longint x, input bit u, input string r);
    item_t it;
    it.cyc = c; it.x = int'(x); it.upd = u; it.req = r;
    sb.push_back(it);
  endtask

  // driver: called at a falling edge; returns at the edge where a new run may start
  task automatic do_run(input int s, input bit glitch, input string r);
    int c;
    bit chg;
    c = cnt;
    run = 1'b1;
    sample = SW'(s);
    model_run(s, chg);
    push(c + 6, m_x, chg, r);        // R9: result six cycles after accept
    push(c + 7, m_x, 1'b0, "R9");    // flag lasts one cycle
    @(negedge clk);
    run = 1'b0;
    if (glitch) begin                // R2: pulse while busy must be ignored
      @(negedge clk);
      run = 1'b1;
      sample = SW'(1023 - s);
      @(negedge clk);
      run = 1'b0;
    end
    while (cnt < c + 7) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].cyc <= cnt) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (it.cyc != cnt || int'(x_o) != it.x || upd_o != it.upd) begin
        errors++;
        $display("FAIL %s: cyc %0d x_o=%0d upd_o=%0b expected cyc %0d x=%0d upd=%0b",
                 it.req, cnt, x_o, upd_o, it.cyc, it.x, it.upd);
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int hits;
    int lf;
    m_x = X_INIT; m_q = 0; m_g = cond_of(X_INIT);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (x_o != XW'(X_INIT) || upd_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: x_o=%0d upd_o=%0b expected x=%0d upd=0", x_o, upd_o, X_INIT);
    end
    // R3/R5: zero-volt sample leaves state and accumulator untouched
    for (int i = 0; i < 4; i++) do_run(512, 1'b0, "R3");
    // R2: busy glitches during upward drive
    for (int i = 0; i < 6; i++) do_run(1023, 1'b1, "R2");
    // R5/R6/R7/R10: full positive drive up to the top rail
    hits = 0;
    while (m_x < XN && hits < 3000) begin do_run(1023, 1'b0, "R7"); hits++; end
    // R8: at the top rail, accumulator saturation per R6
    for (int i = 0; i < 80; i++) do_run(1023, 1'b0, "R8");
    // R7/R10: full negative drive down to the bottom rail
    hits = 0;
    while (m_x > 0 && hits < 3000) begin do_run(0, (hits % 50) == 0, "R7"); hits++; end
    for (int i = 0; i < 40; i++) do_run(0, 1'b0, "R8");
    // R4/R5: mixed pseudo-random samples across the middle of the range
    lf = 32'h1ACE;
    for (int i = 0; i < 400; i++) begin
      lf = lf ^ (lf << 13); lf = lf ^ (lf >>> 17); lf = lf ^ (lf << 5);
      do_run((lf & 32'h3FF) | ((i < 200) ? 32'h200 : 32'h0), 1'b0, "R5");
    end
    for (int i = 0; i < 300; i++) do_run((i % 3 == 0) ? 100 : 900, 1'b0, "R4");
    while (sb.size() > 0) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule